// File: doc/BRIEF.md
# Flash Command Sequencer with Error Status

This block sits between the CPU write path and the flash array engine of an on-chip flash controller. It takes CPU write cycles, each an address and a data byte, and decodes them into commands. Program and block erase are two-cycle commands. Before either one runs, the block checks it against three global rewrite-disable controls, the allocated flash address window and a lock input for each block. A command that passes starts an auto operation on the external array engine: the block gives a one-cycle start pulse, then holds a ready/busy flag low until the engine reports done. A fail indication from the engine is kept as an error.

The status register holds a ready flag and a two-bit error field. The error bits are sticky: a new error is ORed into them, and they return to zero only through a clear-status command or a reset. A read-array command, or FFh written as the second cycle of a pending command, puts the block in array-read mode.

Writes arrive as a valid/ready stream. `wr_ready` is low for as long as an auto operation is running. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the source may hold `wr_valid` high, but nothing is decoded until the operation ends. The block does not buffer these writes: any write that the source withdraws during busy is lost.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset `st_ready` and `wr_ready` are 1, `st_err` is 00, `rd_array` is 1 and `op_start` is 0.
- R2: The error field `st_err` is encoded as follows: 11 = command sequence error, 10 = erase failure, 01 = program failure.
- R3: A first-cycle byte other than 40h (program), 20h (block erase), 50h (clear status) or FFh (read array) ORs 11 into `st_err`.
- R4: In a pending block erase, a second-cycle byte other than D0h or FFh ORs 11 into `st_err` and starts nothing.
- R5: FFh written as the second cycle of a pending program or erase cancels that command. It sets `rd_array` to 1, leaves `st_err` unchanged and starts nothing.
- R6: If any bit of `rw_disable` is 1 on the confirming cycle, the program or erase is refused: 11 is ORed into `st_err` and no start is given.
- R7: A program or erase whose confirming-cycle address is below `FLASH_BASE` or at or above `FLASH_BASE+FLASH_SIZE` is refused with 11 ORed into `st_err`.
- R8: The block that holds an address is the highest index i with address >= `BLK_START[i]`. A command aimed at a block whose `blk_lock` bit is 1 is refused with 11 ORed into `st_err`.
- R9: A valid confirm gives `op_start` high for exactly one cycle, in the cycle after the confirming write is accepted. In that cycle `op_addr` is the confirming-cycle address and `op_erase` is 1 for erase and 0 for program. For a program, `op_data` is the confirming-cycle byte.
- R10: When the engine ends an operation with `eng_done` and `eng_fail` both high, the block ORs 10 into `st_err` for an erase and 01 for a program.
- R11: A first-cycle 50h clears `st_err` to 00. Nothing else lowers any error bit.
- R12: `st_ready` and `wr_ready` go low in the cycle after a launch and return high in the cycle after `eng_done` is sampled. A write offered while they are low is not taken and does not change `st_err`.
- R13: `rd_array` is set by a first-cycle FFh or by a cancel, and is cleared when an operation launches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A CPU write is offered |
| wr_ready | output | 1 | The block can take a write (no operation running) |
| wr_addr | input | AW | Address of the write |
| wr_data | input | 8 | Data byte of the write |
| rw_disable | input | 3 | Global rewrite-disable controls; any bit set refuses program and erase |
| blk_lock | input | NBLK | Rewrite lock for each block |
| op_start | output | 1 | One-cycle start pulse to the array engine |
| op_erase | output | 1 | 1 = erase, 0 = program |
| op_addr | output | AW | Target address of the operation |
| op_data | output | 8 | Byte to program |
| eng_done | input | 1 | The engine has finished the operation |
| eng_fail | input | 1 | The operation failed; valid together with eng_done |
| st_ready | output | 1 | Status ready flag (0 = busy) |
| st_err | output | 2 | Sticky error field |
| rd_array | output | 1 | Array-read mode flag |

## Verification
The bench uses the default parameters: a 16-bit address, a flash window from 8000h to DFFFh, and four blocks of unequal size starting at 8000h, 9000h, A000h and C000h. This window leaves addresses on both sides of it reachable, so the bench can try 7FFFh and E000h just outside the window and DFFFh just inside it. Block edges such as 9FFFh/A000h and BFFFh/C000h are tested with a single block locked. The bench also takes each rewrite-disable bit alone, and compares status and start outputs with a behavioural model on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT2 = 2'd1,
    SEQ_BUSY  = 2'd2
  } seq_state_e;

  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_RDARRAY = 8'hFF;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_SEQ   = 2'b11;
  localparam logic [1:0] ERR_ERASE = 2'b10;
  localparam logic [1:0] ERR_PROG  = 2'b01;

endpackage

// File: rtl/fcs_region.sv
module fcs_region #(
  parameter int unsigned AW         = 16,
  parameter int unsigned NBLK       = 4,
  parameter int unsigned FLASH_BASE = 32'h8000,
  parameter int unsigned FLASH_SIZE = 32'h6000,
  parameter logic [NBLK*AW-1:0] BLK_START = {16'hC000, 16'hA000, 16'h9000, 16'h8000}
) (
  input  logic [AW-1:0]   addr,
  input  logic [NBLK-1:0] blk_lock,
  output logic            out_of_range,
  output logic            blk_locked
);

  localparam logic [32:0] WIN_LO = {1'b0, FLASH_BASE};
  localparam logic [32:0] WIN_HI = {1'b0, FLASH_BASE} + {1'b0, FLASH_SIZE};

  logic [32:0]     addr_w;
  logic [NBLK-1:0] in_blk;

  assign addr_w = {{(33-AW){1'b0}}, addr};

  genvar gi;
  generate
    for (gi = 0; gi < NBLK; gi++) begin : g_blk
      localparam logic [AW-1:0] LO = BLK_START[gi*AW +: AW];
      if (gi == NBLK - 1) begin : g_last
        assign in_blk[gi] = (addr >= LO);
      end else begin : g_mid
        localparam logic [AW-1:0] HI = BLK_START[(gi+1)*AW +: AW];
        assign in_blk[gi] = (addr >= LO) && (addr < HI);
      end
    end
  endgenerate

  assign out_of_range = (addr_w < WIN_LO) || (addr_w >= WIN_HI);
  assign blk_locked   = |(in_blk & blk_lock);

endmodule

// File: rtl/fcs_status.sv
module fcs_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] err_set,
  input  logic       err_clr,
  output logic [1:0] err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 2'b00;
    end else if (err_clr) begin
      err <= 2'b00;
    end else begin
      err <= err | err_set;
    end
  end

endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rw_block,
  input  logic          region_bad,
  input  logic          eng_done,
  input  logic          eng_fail,
  output logic          busy,
  output logic          op_start,
  output logic          op_erase,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          rd_array,
  output logic [1:0]    err_set,
  output logic          err_clr
);

  seq_state_e state;
  logic       pend_erase;

  logic accept, cmd_first, cmd_second;
  logic cancel, bad_confirm, refuse, launch, unknown, fail_done;
  logic known_first;

  assign busy       = (state == SEQ_BUSY);
  assign accept     = wr_valid && !busy;
  assign cmd_first  = accept && (state == SEQ_IDLE);
  assign cmd_second = accept && (state == SEQ_WAIT2);

  always_comb begin
    unique case (wr_data)
      CMD_PROGRAM, CMD_ERASE, CMD_CLRSTAT, CMD_RDARRAY: known_first = 1'b1;
      default:                                          known_first = 1'b0;
    endcase
  end

  assign unknown     = cmd_first && !known_first;
  assign cancel      = cmd_second && (wr_data == CMD_RDARRAY);
  assign bad_confirm = cmd_second && !cancel && pend_erase && (wr_data != CMD_CONFIRM);
  assign refuse      = cmd_second && !cancel && !bad_confirm && (rw_block || region_bad);
  assign launch      = cmd_second && !cancel && !bad_confirm && !refuse;
  assign fail_done   = busy && eng_done && eng_fail;

  always_comb begin
    err_set = ERR_NONE;
    if (unknown || bad_confirm || refuse) begin
      err_set = err_set | ERR_SEQ;
    end
    if (fail_done) begin
      err_set = err_set | (op_erase ? ERR_ERASE : ERR_PROG);
    end
  end

  assign err_clr = cmd_first && (wr_data == CMD_CLRSTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SEQ_IDLE;
      pend_erase <= 1'b0;
      op_start   <= 1'b0;
      op_erase   <= 1'b0;
      op_addr    <= '0;
      op_data    <= 8'h00;
      rd_array   <= 1'b1;
    end else begin
      op_start <= launch;
      unique case (state)
        SEQ_IDLE: begin
          if (cmd_first) begin
            if (wr_data == CMD_PROGRAM) begin
              state      <= SEQ_WAIT2;
              pend_erase <= 1'b0;
            end else if (wr_data == CMD_ERASE) begin
              state      <= SEQ_WAIT2;
              pend_erase <= 1'b1;
            end else if (wr_data == CMD_RDARRAY) begin
              rd_array <= 1'b1;
            end
          end
        end
        SEQ_WAIT2: begin
          if (cmd_second) begin
            if (launch) begin
              state    <= SEQ_BUSY;
              op_erase <= pend_erase;
              op_addr  <= wr_addr;
              op_data  <= wr_data;
              rd_array <= 1'b0;
            end else begin
              state <= SEQ_IDLE;
              if (cancel) begin
                rd_array <= 1'b1;
              end
            end
          end
        end
        SEQ_BUSY: begin
          if (eng_done) begin
            state <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int unsigned AW         = 16,
  parameter int unsigned NBLK       = 4,
  parameter int unsigned FLASH_BASE = 32'h8000,
  parameter int unsigned FLASH_SIZE = 32'h6000,
  parameter logic [NBLK*AW-1:0] BLK_START = {16'hC000, 16'hA000, 16'h9000, 16'h8000}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [2:0]      rw_disable,
  input  logic [NBLK-1:0] blk_lock,
  output logic            op_start,
  output logic            op_erase,
  output logic [AW-1:0]   op_addr,
  output logic [7:0]      op_data,
  input  logic            eng_done,
  input  logic            eng_fail,
  output logic            st_ready,
  output logic [1:0]      st_err,
  output logic            rd_array
);

  logic       out_of_range, blk_locked, busy, err_clr;
  logic [1:0] err_set;

  fcs_region #(
    .AW(AW), .NBLK(NBLK), .FLASH_BASE(FLASH_BASE),
    .FLASH_SIZE(FLASH_SIZE), .BLK_START(BLK_START)
  ) u_region (
    .addr(wr_addr), .blk_lock(blk_lock),
    .out_of_range(out_of_range), .blk_locked(blk_locked)
  );

  fcs_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rw_block(|rw_disable), .region_bad(out_of_range || blk_locked),
    .eng_done(eng_done), .eng_fail(eng_fail),
    .busy(busy), .op_start(op_start), .op_erase(op_erase),
    .op_addr(op_addr), .op_data(op_data), .rd_array(rd_array),
    .err_set(err_set), .err_clr(err_clr)
  );

  fcs_status u_status (
    .clk(clk), .rst_n(rst_n),
    .err_set(err_set), .err_clr(err_clr), .err(st_err)
  );

  assign wr_ready = !busy;
  assign st_ready = !busy;

endmodule

// File: rtl/fcs_checks.sv
module fcs_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic [2:0] rw_disable,
  input logic       eng_done,
  input logic       st_ready,
  input logic [1:0] st_err,
  input logic       op_start
);

  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !op_start);

  p_start_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wr_valid && wr_ready));

  p_start_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> (!wr_ready && !st_ready));

  p_done_frees_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_ready && eng_done) |=> st_ready);

  p_no_start_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> ($past(rw_disable) == 3'b000));

  p_err_clear_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st_err) & ~st_err) != 2'b00) |-> $past(wr_valid && wr_ready && (wr_data == 8'h50)));

endmodule

bind flash_cmd_seq fcs_checks u_checks (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_data(wr_data), .rw_disable(rw_disable), .eng_done(eng_done),
  .st_ready(st_ready), .st_err(st_err), .op_start(op_start)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic [2:0]  rw_disable = 3'b000;
  logic [3:0]  blk_lock = 4'b0000;
  logic        op_start, op_erase;
  logic [15:0] op_addr;
  logic [7:0]  op_data;
  logic        eng_done = 1'b0;
  logic        eng_fail = 1'b0;
  logic        st_ready, rd_array;
  logic [1:0]  st_err;

  int n_chk = 0;
  int n_fail = 0;
  int n_start = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  flash_cmd_seq #(
    .AW(16), .NBLK(4), .FLASH_BASE(32'h8000), .FLASH_SIZE(32'h6000),
    .BLK_START({16'hC000, 16'hA000, 16'h9000, 16'h8000})
  ) uut (.*);

  // behavioural reference model
  int m_busy, m_pend, m_err, m_ra, m_start, m_erase, m_addr, m_data;

  function automatic int blk_of(input int a);
    int starts[4] = '{'h8000, 'h9000, 'hA000, 'hC000};
    int idx = -1;
    foreach (starts[i]) if (a >= starts[i]) idx = i;
    return idx;
  endfunction

  function automatic bit allowed(input int a);
    if (rw_disable != 0) return 0;
    if (a < 'h8000 || a >= 'hE000) return 0;
    if (blk_lock[blk_of(a)]) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (op_start) n_start++;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_err = 0; m_ra = 1; m_start = 0;
      m_erase = 0; m_addr = 0; m_data = 0;
    end else begin
      m_start = 0;
      if (m_busy != 0) begin
        if (eng_done) begin
          m_busy = 0;
          if (eng_fail) m_err = m_err | (m_erase != 0 ? 2 : 1);
        end
      end else if (wr_valid) begin
        if (m_pend == 0) begin
          if (wr_data == 8'h40) m_pend = 1;
          else if (wr_data == 8'h20) m_pend = 2;
          else if (wr_data == 8'h50) m_err = 0;
          else if (wr_data == 8'hFF) m_ra = 1;
          else m_err = 3;
        end else begin
          if (wr_data == 8'hFF) m_ra = 1;
          else if (m_pend == 2 && wr_data != 8'hD0) m_err = 3;
          else if (!allowed(int'(wr_addr))) m_err = 3;
          else begin
            m_start = 1; m_busy = 1; m_ra = 0;
            m_erase = (m_pend == 2) ? 1 : 0;
            m_addr = int'(wr_addr); m_data = int'(wr_data);
          end
          m_pend = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R12 wr_ready", int'(wr_ready), m_busy == 0 ? 1 : 0);
      chk("R12 st_ready", int'(st_ready), m_busy == 0 ? 1 : 0);
      chk("R2 st_err", int'(st_err), m_err);
      chk("R13 rd_array", int'(rd_array), m_ra);
      chk("R9 op_start", int'(op_start), m_start);
      if (m_start != 0) begin
        chk("R9 op_erase", int'(op_erase), m_erase);
        chk("R9 op_addr", int'(op_addr), m_addr);
        if (m_erase == 0) chk("R9 op_data", int'(op_data), m_data);
      end
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic engine(input logic fail);
    repeat (3) @(negedge clk);
    eng_done = 1'b1; eng_fail = fail;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_status();
    bus_wr(16'h8000, 8'h50);
    chk("R11 cleared", int'(st_err), 0);
  endtask

  task automatic refused(input string tag, input logic [15:0] a, input logic [7:0] c1, input logic [7:0] c2);
    int s0 = n_start;
    bus_wr(a, c1);
    bus_wr(a, c2);
    @(negedge clk);
    chk({tag, " err"}, int'(st_err), 3);
    chk({tag, " no start"}, n_start, s0);
    clear_status();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 ready", int'(st_ready), 1);
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 err", int'(st_err), 0);
    chk("R1 rd_array", int'(rd_array), 1);
    chk("R1 op_start", int'(op_start), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 unknown first byte
    bus_wr(16'h8000, 8'h33);
    chk("R3 seq err", int'(st_err), 3);

    // R9 program launch; R12 busy writes ignored
    bus_wr(16'h8000, 8'h40);
    bus_wr(16'h8123, 8'hA5);
    chk("R9 start", int'(op_start), 1);
    chk("R9 addr", int'(op_addr), 'h8123);
    chk("R9 data", int'(op_data), 'hA5);
    chk("R13 cleared by launch", int'(rd_array), 0);
    wr_valid = 1'b1; wr_data = 8'h50;
    @(negedge clk);
    chk("R12 busy", int'(st_ready), 0);
    @(negedge clk);
    wr_valid = 1'b0;
    engine(1'b0);
    chk("R12 busy write ignored", int'(st_err), 3);
    chk("R12 ready again", int'(st_ready), 1);
    clear_status();

    // R5 cancel
    bus_wr(16'h8000, 8'h40);
    bus_wr(16'h8000, 8'hFF);
    chk("R5 no err", int'(st_err), 0);
    chk("R5 rd_array", int'(rd_array), 1);

    // R10 erase failure then program failure ORed
    bus_wr(16'hA000, 8'h20);
    bus_wr(16'hA000, 8'hD0);
    chk("R9 erase flag", int'(op_erase), 1);
    engine(1'b1);
    chk("R10 erase fail", int'(st_err), 2);
    bus_wr(16'h8010, 8'h40);
    bus_wr(16'h8010, 8'h3C);
    engine(1'b1);
    chk("R11 OR of errors", int'(st_err), 3);
    clear_status();
    bus_wr(16'h8010, 8'h40);
    bus_wr(16'h8010, 8'h3C);
    engine(1'b1);
    chk("R10 program fail", int'(st_err), 1);
    clear_status();

    // R4 bad erase confirm
    refused("R4", 16'h8000, 8'h20, 8'h55);

    // R6 each disable bit
    for (int k = 0; k < 3; k++) begin
      rw_disable = 3'b001 << k;
      refused("R6", 16'h8000, 8'h40, 8'h12);
    end
    rw_disable = 3'b000;

    // R7 window edges
    refused("R7 below", 16'h7FFF, 8'h40, 8'h12);
    refused("R7 above", 16'hE000, 8'h20, 8'hD0);
    bus_wr(16'hDFFF, 8'h40);
    bus_wr(16'hDFFF, 8'h77);
    chk("R7 top inside", int'(op_start), 1);
    engine(1'b0);

    // R8 lock on block 2 (A000..BFFF)
    blk_lock = 4'b0100;
    refused("R8 low edge", 16'hA000, 8'h40, 8'h01);
    refused("R8 high edge", 16'hBFFF, 8'h20, 8'hD0);
    bus_wr(16'hC000, 8'h20);
    bus_wr(16'hC000, 8'hD0);
    chk("R8 next block", int'(op_start), 1);
    engine(1'b0);
    bus_wr(16'h9FFF, 8'h40);
    bus_wr(16'h9FFF, 8'h02);
    chk("R8 prev block", int'(op_start), 1);
    engine(1'b0);
    blk_lock = 4'b0000;

    // R13 first-cycle read array
    bus_wr(16'h8000, 8'hFF);
    chk("R13 set", int'(rd_array), 1);
    chk("R2 none", int'(st_err), 0);

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule